// File: doc/BRIEF.md
# Word Arithmetic Right Shifter

This execution unit shifts a 32-bit signed word to the right by an amount read from a second operand, filling the vacated high positions with the sign bit. Only the six lowest bits of the amount operand count. Amounts from 32 to 63 therefore push every source bit out and leave a word made only of sign bits. Alongside the result the unit reports a carry flag. The flag shows whether any 1 bit left the low end of the word.

An optional record step writes a 4-bit condition field that classifies the result as negative, positive or zero, and copies in a summary-overflow bit supplied by the caller. The condition field is a held register. It changes only for operations whose record bit is set, and keeps its value across all other operations.

Operands are taken when the input valid strobe is high. Result, carry and output valid appear on registered outputs on the next clock edge.

Top module: `wsra_unit`

## Requirements
- R1: The shift amount is `in_amt[5:0]`. Bits 31 to 6 of `in_amt` have no effect on any output.
- R2: For amounts 1 to 31, `out_result` equals `in_src` shifted right by the amount, and every vacated upper bit holds a copy of `in_src[31]`.
- R3: For amounts 32 to 63, `out_result` is 32'h0000_0000 when `in_src[31]` is 0 and 32'hFFFF_FFFF when it is 1.
- R4: An amount of 0 gives `out_result` equal to `in_src` and `out_carry` equal to 0.
- R5: `out_carry` is 1 exactly when at least one 1 bit lies in the shifted-out low positions `in_src[amt-1:0]`. For amounts of 32 or more, all 32 source bits count as shifted out.
- R6: When an accepted operation has `in_rec` = 1, `out_cond` becomes {LT, GT, EQ, SO} in bits [3:0], with LT in bit 3. LT is 1 for a negative result, GT is 1 for a non-zero non-negative result, EQ is 1 for a zero result, and SO (bit 0) copies `in_so`.
- R7: `out_cond` keeps its value in every cycle that does not accept an operation with `in_rec` = 1.
- R8: `out_valid` is high in exactly the cycle after `in_valid` is high. `out_result` and `out_carry` hold their values while no operation is accepted.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_result`, `out_carry` and `out_cond` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe; the operation is accepted on the clock edge |
| in_src | input | 32 | Signed word to shift |
| in_amt | input | 32 | Amount operand; only bits [5:0] are used |
| in_rec | input | 1 | Update the condition field with this operation |
| in_so | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | A 1 bit was shifted out |
| out_cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The carry and the condition record are computed in the same cycle, and the condition hold must also coincide with a new result. The bench provokes this with back-to-back strobes. A recorded operation is followed at once by an unrecorded one, whose carry and result differ from the first. The bench then checks that result and carry follow the second operation while the condition field still shows the first. Negative sources with amounts of 32 or more are judged in the same way: the all-ones result, the set carry and the LT classification must all appear together in one output cycle.

// File: rtl/wsra_pkg.sv
package wsra_pkg;
  localparam int WORD_W = 32;
  localparam int STAGES = $clog2(WORD_W);
  localparam int AMT_W  = STAGES + 1;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/wsra_amount.sv
module wsra_amount #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     opnd,
  output logic [AMT_W-1:0] amt,
  output logic             big
);
  localparam int STAGES = $clog2(W);

  assign amt = opnd[AMT_W-1:0];
  assign big = |amt[AMT_W-1:STAGES];
endmodule

// File: rtl/wsra_barrel.sv
module wsra_barrel #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     src,
  input  logic [AMT_W-1:0] amt,
  input  logic             big,
  output logic [W-1:0]     dout
);
  localparam int STAGES = $clog2(W);

  logic          sgn;
  logic [W-1:0]  st [STAGES+1];

  assign sgn   = src[W-1];
  assign st[0] = src;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int D = 2 ** k;
    assign st[k+1] = amt[k] ? {{D{sgn}}, st[k][W-1:D]} : st[k];
  end

  assign dout = big ? {W{sgn}} : st[STAGES];
endmodule

// File: rtl/wsra_lostbits.sv
module wsra_lostbits #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     src,
  input  logic [AMT_W-1:0] amt,
  output logic             carry
);
  logic [W-1:0] gone;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign gone[i] = (AMT_W'(i) < amt) ? src[i] : 1'b0;
  end

  assign carry = |gone;
endmodule

// File: rtl/wsra_cond.sv
module wsra_cond
  import wsra_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         so,
  output cond_t        cond
);
  logic zero;

  assign zero    = (res == '0);
  assign cond.lt = res[W-1];
  assign cond.gt = !res[W-1] && !zero;
  assign cond.eq = zero;
  assign cond.so = so;
endmodule

// File: rtl/wsra_unit.sv
module wsra_unit
  import wsra_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int AMT_W = $clog2(W) + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_amt,
  input  logic         in_rec,
  input  logic         in_so,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_carry,
  output logic [3:0]   out_cond
);
  logic [AMT_W-1:0] amt;
  logic             big;
  logic [W-1:0]     res_c;
  logic             carry_c;
  cond_t            cond_c;
  cond_t            cond_q;

  wsra_amount #(.W(W), .AMT_W(AMT_W)) amt_i (
    .opnd(in_amt), .amt(amt), .big(big)
  );

  wsra_barrel #(.W(W), .AMT_W(AMT_W)) bar_i (
    .src(in_src), .amt(amt), .big(big), .dout(res_c)
  );

  wsra_lostbits #(.W(W), .AMT_W(AMT_W)) lost_i (
    .src(in_src), .amt(amt), .carry(carry_c)
  );

  wsra_cond #(.W(W)) cond_i (
    .res(res_c), .so(in_so), .cond(cond_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
      cond_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res_c;
        out_carry  <= carry_c;
        if (in_rec) cond_q <= cond_c;
      end
    end
  end

  assign out_cond = cond_q;
endmodule

// File: rtl/wsra_unit_chk.sv
module wsra_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_src,
  input logic [W-1:0] in_amt,
  input logic         in_rec,
  input logic         in_so,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         out_carry,
  input logic [3:0]   out_cond
);
  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_carry)));
  assert_cond_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_rec) |=> $stable(out_cond));
  assert_cond_class_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rec) |=> ($countones(out_cond[3:1]) == 1 && out_cond[0] == $past(in_so)));
  assert_zero_amt_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_amt[5:0] == 6'd0) |=> (out_result == $past(in_src) && !out_carry));
  assert_big_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_amt[5]) |=> (out_result == {W{$past(in_src[W-1])}}));
  assert_big_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_amt[5]) |=> (out_carry == (|$past(in_src))));
endmodule

bind wsra_unit wsra_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_amt(in_amt),
  .in_rec(in_rec), .in_so(in_so), .out_valid(out_valid), .out_result(out_result),
  .out_carry(out_carry), .out_cond(out_cond)
);

// File: tb/wsra_unit_tb_top.sv
module wsra_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_src;
  logic [31:0] in_amt;
  logic        in_rec;
  logic        in_so;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry;
  logic [3:0]  out_cond;

  int total = 0;
  int bad   = 0;
  logic [3:0] exp_cond = 4'b0;

  always #2 clk = ~clk;

  wsra_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_amt(in_amt),
    .in_rec(in_rec), .in_so(in_so), .out_valid(out_valid), .out_result(out_result),
    .out_carry(out_carry), .out_cond(out_cond)
  );

  // stimulus and expected values: src, amt, rec, so, result, carry
  localparam int NV = 13;
  localparam logic [31:0] V_SRC [NV] = '{
    32'h0000_00F0, 32'h0000_00F0, 32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFF,
    32'h1234_5678, 32'h8765_4321, 32'h0000_0000, 32'h4000_0000, 32'hFFFF_FF00,
    32'h0001_0000, 32'hF000_0000, 32'h0000_8000};
  localparam logic [31:0] V_AMT [NV] = '{
    32'd4, 32'd5, 32'd31, 32'd1, 32'd31,
    32'd0, 32'd32, 32'd63, 32'h0000_0040, 32'hFFFF_FFC8,
    32'h0000_0150, 32'h0000_003F, 32'd16};
  localparam logic V_REC [NV] = '{1,0,1,1,1,0,1,1,1,0,1,1,0};
  localparam logic V_SO  [NV] = '{0,1,1,0,1,0,0,1,0,1,1,0,1};
  localparam logic [31:0] V_RES [NV] = '{
    32'h0000_000F, 32'h0000_0007, 32'hFFFF_FFFF, 32'hC000_0000, 32'h0000_0000,
    32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0000, 32'h4000_0000, 32'hFFFF_FFFF,
    32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic V_CAR [NV] = '{0,1,0,1,1,0,1,0,0,0,0,1,1};

  function automatic logic [3:0] cond_of(input logic [31:0] r, input logic so);
    logic z;
    z = (r == 32'h0);
    return {r[31], !r[31] && !z, z, so};
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one accepted operation; result visible at the following negedge
  task automatic issue(input logic [31:0] s, input logic [31:0] a, input logic r, input logic so);
    @(negedge clk);
    in_src = s; in_amt = a; in_rec = r; in_so = so; in_valid = 1'b1;
    if (r) exp_cond = cond_of(((a[5:0] >= 6'd32) ? {32{s[31]}} :
                       32'($signed(s) >>> a[4:0])), so);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_src = '0; in_amt = '0; in_rec = 1'b0; in_so = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check32("R9 valid", {31'b0, out_valid}, 32'h0);
    check32("R9 result", out_result, 32'h0);
    check32("R9 carry", {31'b0, out_carry}, 32'h0);
    check32("R9 cond", {28'b0, out_cond}, 32'h0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      issue(V_SRC[i], V_AMT[i], V_REC[i], V_SO[i]);
      check32($sformatf("R8 valid v%0d", i), {31'b0, out_valid}, 32'h1);
      check32($sformatf("R2/R3/R1 result v%0d", i), out_result, V_RES[i]);
      check32($sformatf("R5 carry v%0d", i), {31'b0, out_carry}, {31'b0, V_CAR[i]});
      check32($sformatf("R6/R7 cond v%0d", i), {28'b0, out_cond}, {28'b0, exp_cond});
    end

    // R8 idle: valid low, outputs hold
    @(negedge clk);
    check32("R8 idle valid", {31'b0, out_valid}, 32'h0);
    check32("R8 hold result", out_result, 32'h0);

    // R4 negative source with zero amount and junk upper bits (R1)
    issue(32'h8000_00FF, 32'hABCD_EF00, 1'b1, 1'b1);
    check32("R4 pass", out_result, 32'h8000_00FF);
    check32("R4 carry", {31'b0, out_carry}, 32'h0);
    check32("R6 cond neg", {28'b0, out_cond}, 32'h9);

    // back-to-back: recorded then unrecorded, R6 + R7 in same output cycle
    @(negedge clk);
    in_src = 32'h0000_0010; in_amt = 32'd4; in_rec = 1'b1; in_so = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check32("R6 b2b first cond", {28'b0, out_cond}, 32'h4);
    check32("R5 b2b first carry", {31'b0, out_carry}, 32'h0);
    in_src = 32'hFFFF_FFFF; in_amt = 32'd40; in_rec = 1'b0; in_so = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check32("R3 b2b result", out_result, 32'hFFFF_FFFF);
    check32("R5 b2b carry", {31'b0, out_carry}, 32'h1);
    check32("R7 b2b cond hold", {28'b0, out_cond}, 32'h4);
    check32("R8 b2b valid", {31'b0, out_valid}, 32'h1);

    // R6 zero result with SO
    issue(32'h0000_0003, 32'd2, 1'b1, 1'b1);
    check32("R6 eq cond", {28'b0, out_cond}, 32'h3);
    check32("R5 low ones", {31'b0, out_carry}, 32'h1);

    // R9 reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check32("R9 post result", out_result, 32'h0);
    check32("R9 post cond", {28'b0, out_cond}, 32'h0);
    check32("R9 post carry", {31'b0, out_carry}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule